// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a reference clock of any of several frequencies into a steady one-microsecond tick. The division ratio is rational rather than integer. A single 16-bit configuration word holds two fields: a period length and a tick count. The block issues exactly that many ticks in every period of that many reference cycles. Because of this it reaches 1 MHz from references such as 19.2 MHz, where no integer divisor works. A phase accumulator spreads the ticks across each period as evenly as it can.

Each tick advances a free-running microsecond counter that wraps at its full width. The tick also leaves the block as a one-cycle pulse for neighbouring timers. Software reaches the block through a small register port with valid/ready handshaking. The port has three registers: the configuration word, the read-only counter and a freeze control. The configuration word reads back exactly what was written, so it survives a save-and-restore sequence around a low-power state.

There are two state machines. The port sequencer has states `BUS_IDLE` and `BUS_RESP`. It moves IDLE→RESP when a request arrives and RESP→IDLE unconditionally on the following cycle. The divider has states `DIV_RUN` and `DIV_HOLD`. It moves RUN→HOLD on a freeze-register write with bit 0 set, and HOLD→RUN on a freeze-register write with bit 0 clear.

Top module: `ustb_timebase`

## Requirements
- R1: After reset the configuration register reads 0x0000000B, the freeze register reads 0 and the counter reads 0.
- R2: A request (`bus_valid` high while the port is idle) is taken on that clock edge. `bus_ready` is then high for exactly the next cycle, with `bus_rdata` valid alongside it. The offsets are: counter at 0x10, configuration at 0x14, freeze at 0x4C (bit 0). A read of any other offset returns 0, and a write to any other offset changes nothing.
- R3: Configuration bits [7:0] hold the period length minus one (D-1), and bits [15:8] hold the tick count minus one (N-1). A read returns the last 16 bits written, with zero in bits [31:16].
- R4: Starting from a cleared phase, k enabled reference cycles yield exactly floor(k·N/D) ticks. For example, 0x000B gives 1 tick per 12 cycles and 0x045F gives 5 ticks per 96 cycles.
- R5: When N ≥ D, a tick occurs on every enabled cycle and never more than one per cycle.
- R6: The counter rises by one on the same clock edge that raises `us_tick`, and it wraps from all-ones to zero.
- R7: A write to the counter offset leaves the counter value unchanged.
- R8: While frozen, the counter and `us_tick` hold still and the phase accumulator keeps its value. After the freeze is released, counting resumes from that preserved phase.
- R9: A write to the configuration register clears the phase accumulator, and no tick is produced on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | DATA_W | Read data, valid with bus_ready |
| us_tick | output | 1 | One-cycle microsecond tick |

## Verification
The bench keeps FRAC_W at 8. This makes the real configuration codes for 12, 13, 19.2 and 26 MHz usable directly, together with ratios where the tick count exceeds the period and so saturates. It builds the counter with COUNT_W = 12, so a wrap past all-ones arrives after about four thousand ticks and stays within the run. Every measurement is bracketed by freeze writes, which fixes the number of enabled edges exactly. That in turn lets the bench check phase carry-over across a freeze and phase loss on a configuration write.

// File: rtl/ustb_pkg.sv
package ustb_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CONFIG = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_FREEZE = 8'h4C;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic {
        DIV_RUN  = 1'b0,
        DIV_HOLD = 1'b1
    } div_state_e;
endpackage

// File: rtl/ustb_counter.sv
module ustb_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (inc_i)
            count_q <= count_q + W'(1);
    end

    assign count_o = count_q;

    // R6: one step per tick, wrap included
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> (count_q == $past(count_q) + W'(1)));
    assert_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(count_q));
endmodule

// File: rtl/ustb_frac_div.sv
module ustb_frac_div
    import ustb_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*FRAC_W-1:0]   cfg_i,
    input  logic                  clr_i,
    input  logic                  frz_wr_i,
    input  logic                  frz_val_i,
    output logic                  fire_o,
    output logic                  tick_o,
    output logic                  frozen_o
);
    localparam int SW = FRAC_W + 2;

    div_state_e   state_q, state_d;
    logic [SW-1:0] den, num, n_eff, sum, acc_q, acc_d;
    logic          run, fire, tick_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= DIV_RUN;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_RUN:  if (frz_wr_i &&  frz_val_i) state_d = DIV_HOLD;
            DIV_HOLD: if (frz_wr_i && !frz_val_i) state_d = DIV_RUN;
            default:  state_d = DIV_RUN;
        endcase
    end

    // ratio decode, saturating the tick count at the period length
    always_comb begin
        den   = SW'(cfg_i[FRAC_W-1:0]) + SW'(1);
        num   = SW'(cfg_i[2*FRAC_W-1:FRAC_W]) + SW'(1);
        n_eff = (num > den) ? den : num;
        sum   = acc_q + n_eff;
    end

    // outputs and accumulator update
    always_comb begin
        run   = (state_q == DIV_RUN);
        fire  = run && !clr_i && (sum >= den);
        acc_d = acc_q;
        if (clr_i)
            acc_d = '0;
        else if (run)
            acc_d = fire ? (sum - den) : sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= fire;
        end
    end

    assign fire_o   = fire;
    assign tick_o   = tick_q;
    assign frozen_o = (state_q == DIV_HOLD);

    // R4: phase stays below the period
    assert_acc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < den);
    // R5: saturated ratio ticks every enabled cycle
    assert_full_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr_i && num >= den) |=> tick_q);
    // R8: hold keeps phase and silences the tick
    assert_hold_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_HOLD && !clr_i) |=> $stable(acc_q));
    assert_hold_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DIV_HOLD) |=> !tick_q);
    // R9: config write restarts the phase
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_q == '0 && !tick_q));
endmodule

// File: rtl/ustb_regs.sv
module ustb_regs
    import ustb_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FRAC_W    = 8,
    parameter int COUNT_W   = 32,
    parameter int CFG_RESET = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_ready,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [COUNT_W-1:0]    count_i,
    input  logic                  frozen_i,
    output logic [2*FRAC_W-1:0]   cfg_o,
    output logic                  cfg_wr_o,
    output logic                  frz_wr_o,
    output logic                  frz_val_o
);
    localparam int CFG_W = 2 * FRAC_W;

    bus_state_e         state_q, state_d;
    logic               accept;
    logic [CFG_W-1:0]   cfg_q;
    logic [DATA_W-1:0]  rdata_q, rd_mux, count_ext;
    logic               unused_wdata_hi;

    // count width adapted to the data path
    generate
        if (COUNT_W < DATA_W) begin : g_count_pad
            assign count_ext = {{(DATA_W-COUNT_W){1'b0}}, count_i};
        end else begin : g_count_cut
            assign count_ext = count_i[DATA_W-1:0];
        end
    endgenerate

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= BUS_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_valid) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        accept    = (state_q == BUS_IDLE) && bus_valid;
        cfg_wr_o  = accept && bus_write && (bus_addr == OFF_CONFIG);
        frz_wr_o  = accept && bus_write && (bus_addr == OFF_FREEZE);
        frz_val_o = bus_wdata[0];
        unique case (bus_addr)
            OFF_COUNT:  rd_mux = count_ext;
            OFF_CONFIG: rd_mux = DATA_W'(cfg_q);
            OFF_FREEZE: rd_mux = DATA_W'(frozen_i);
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= CFG_W'(CFG_RESET);
            rdata_q <= '0;
        end else begin
            if (cfg_wr_o)
                cfg_q <= bus_wdata[CFG_W-1:0];
            if (accept)
                rdata_q <= rd_mux;
        end
    end

    assign bus_ready = (state_q == BUS_RESP);
    assign bus_rdata = rdata_q;
    assign cfg_o     = cfg_q;

    // R2: ready is a single-cycle pulse after a request
    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);
    assert_ready_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_valid));
    // R3: config keeps exactly what was written
    assert_cfg_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_o |=> (cfg_q == $past(bus_wdata[CFG_W-1:0])));
    assert_cfg_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_o |=> $stable(cfg_q));
endmodule

// File: rtl/ustb_timebase.sv
module ustb_timebase
    import ustb_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int FRAC_W    = 8,
    parameter int COUNT_W   = 32,
    parameter int CFG_RESET = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              us_tick
);
    logic [2*FRAC_W-1:0] cfg;
    logic                cfg_wr, frz_wr, frz_val, fire, frozen;
    logic [COUNT_W-1:0]  count;

    ustb_regs #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W),
        .COUNT_W(COUNT_W), .CFG_RESET(CFG_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .count_i(count), .frozen_i(frozen),
        .cfg_o(cfg), .cfg_wr_o(cfg_wr),
        .frz_wr_o(frz_wr), .frz_val_o(frz_val)
    );

    ustb_frac_div #(.FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .cfg_i(cfg), .clr_i(cfg_wr),
        .frz_wr_i(frz_wr), .frz_val_i(frz_val),
        .fire_o(fire), .tick_o(us_tick), .frozen_o(frozen)
    );

    ustb_counter #(.W(COUNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .inc_i(fire), .count_o(count)
    );

    // R8: a frozen divider never advances the counter
    assert_freeze_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(count));
    // R6: the pulse leaves together with the counter step
    assert_tick_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |-> (count != $past(count)));
endmodule

// File: tb/test_ustb_timebase.sv
module test_ustb_timebase;
    localparam int CW = 12;
    localparam int CMASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        us_tick;

    int n_vec = 0;
    int n_bad = 0;
    int tick_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ustb_timebase #(.COUNT_W(CW)) i_ustb_timebase (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .us_tick(us_tick)
    );

    always @(negedge clk) if (rst_n && us_tick) tick_cnt++;

    // {cfg[15:0], K[15:0]}: enabled edges = K + 2
    localparam logic [31:0] VEC [8] = '{
        {16'h000B, 16'd238}, {16'h000C, 16'd258}, {16'h0019, 16'd518},
        {16'h045F, 16'd958}, {16'h0000, 16'd98},  {16'h0302, 16'd48},
        {16'h0207, 16'd78},  {16'hFF00, 16'd30}
    };

    function automatic int exp_ticks(input int cfg, input int edges);
        int d = (cfg & 255) + 1;
        int n = ((cfg >> 8) & 255) + 1;
        if (n > d) n = d;
        return (edges * n) / d;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] q);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        do @(negedge clk); while (!bus_ready);
        q = bus_rdata;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] q;
        xfer(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] q);
        xfer(1'b0, a, '0, q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] c0, c1, q;
        int t0, t1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, q); check("R1 counter", q, 32'h0);
        rd(8'h14, q); check("R1 config", q, 32'h0000000B);
        rd(8'h4C, q); check("R1 freeze", q, 32'h0);

        // R2 handshake timing: ready exactly one cycle after acceptance
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = 8'h14;
        @(negedge clk); check("R2 ready after accept", {31'b0, bus_ready}, 32'h1);
        bus_valid = 1'b0;
        @(negedge clk); check("R2 ready one cycle", {31'b0, bus_ready}, 32'h0);

        // vector table: R4 / R5 rates
        for (int i = 0; i < 8; i++) begin
            int cfg = int'(VEC[i][31:16]);
            int k   = int'(VEC[i][15:0]);
            int e   = exp_ticks(cfg, k + 2);
            wr(8'h4C, 32'h1);
            wr(8'h14, 32'(cfg));
            rd(8'h10, c0); t0 = tick_cnt;
            wr(8'h4C, 32'h0);
            repeat (k) @(negedge clk);
            wr(8'h4C, 32'h1);
            rd(8'h10, c1); t1 = tick_cnt;
            check($sformatf("R4 R5 count cfg=%0h", cfg), (c1 - c0) & CMASK, 32'(e) & CMASK);
            check($sformatf("R4 R6 ticks cfg=%0h", cfg), 32'(t1 - t0), 32'(e));
        end

        // R3 readback of written value, upper bits dropped
        wr(8'h14, 32'hFFFF_1234);
        rd(8'h14, q); check("R3 readback", q, 32'h0000_1234);
        rd(8'h4C, q); check("R2 freeze readback", q, 32'h1);

        // R7 counter write ignored; R2 unmapped offset
        rd(8'h10, c0);
        wr(8'h10, 32'h0000_05A5);
        rd(8'h10, c1); check("R7 counter write ignored", c1, c0);
        wr(8'h20, 32'h0000_00FF);
        rd(8'h20, q); check("R2 unmapped read", q, 32'h0);
        rd(8'h14, q); check("R2 unmapped write ignored", q, 32'h0000_1234);

        // R8 freeze keeps phase: 8 edges, hold, 4 edges -> one tick at 1/12
        wr(8'h14, 32'h000B);
        rd(8'h10, c0); t0 = tick_cnt;
        wr(8'h4C, 32'h0); repeat (6) @(negedge clk); wr(8'h4C, 32'h1);
        repeat (50) @(negedge clk);
        rd(8'h10, c1); check("R8 frozen counter", c1, c0);
        check("R8 frozen tick", 32'(tick_cnt - t0), 32'h0);
        wr(8'h4C, 32'h0); repeat (2) @(negedge clk); wr(8'h4C, 32'h1);
        rd(8'h10, c1); check("R8 phase kept", (c1 - c0) & CMASK, 32'h1);

        // R9 config write clears phase: 8 edges, rewrite, 11 edges -> none
        wr(8'h14, 32'h000B);
        rd(8'h10, c0);
        wr(8'h4C, 32'h0); repeat (6) @(negedge clk); wr(8'h4C, 32'h1);
        wr(8'h14, 32'h000B);
        wr(8'h4C, 32'h0); repeat (9) @(negedge clk); wr(8'h4C, 32'h1);
        rd(8'h10, c1); check("R9 phase cleared", (c1 - c0) & CMASK, 32'h0);
        wr(8'h4C, 32'h0); wr(8'h4C, 32'h1);
        rd(8'h10, c1); check("R9 restart phase", (c1 - c0) & CMASK, 32'h1);

        // R6 wrap: every cycle, 4300 edges through a 12-bit counter
        wr(8'h14, 32'h0000);
        rd(8'h10, c0); t0 = tick_cnt;
        wr(8'h4C, 32'h0); repeat (4298) @(negedge clk); wr(8'h4C, 32'h1);
        rd(8'h10, c1); t1 = tick_cnt;
        check("R6 wrap value", c1, 32'((int'(c0) + 4300) & CMASK));
        check("R6 wrap ticks", 32'(t1 - t0), 32'd4300);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule